// File: doc/BRIEF.md
# Serial Character Transmitter

This block is the sending half of an asynchronous serial port. Software programs a control byte and a format byte, then writes a data byte into a holding register. On the next bit-rate tick the holding register is copied into a shift register, and the character goes out on one line, least significant bit first, framed by a low start bit and a high stop bit.

The format byte selects between a short (10-bit) and a long (11-bit) character. When parity is on, the parity bit takes the slot of the highest data bit, so the frame length never changes with parity. The transmitter can also hold the line low for whole character times, which is a break. Two status flags report when the holding register has been taken and when the line has gone quiet. Each flag can be routed to one shared interrupt output.

Top module: `sertx_top`

Register map (addr): 0 control, 1 format, 2 data (low 8 bits), 3 status (read only). Control bits: [7] empty interrupt enable, [6] done interrupt enable, [5] receive-full enable, [4] idle enable, [3] transmit enable, [2] receive enable, [1] receive wake, [0] break. Format bits: [0] long mode, [1] parity on, [2] odd parity, [3] ninth data bit, [7:4] read as 0. Status bits: [0] holding empty, [1] transmission done.

## Requirements
- R1: After reset, control and format read 0, txd is 1, irq is 0, and status reads 3 (holding empty and transmission done both 1).
- R2: The control register at address 0 keeps and reads back all 8 bits written, with the bit layout in the register map above.
- R3: With format 0 (short mode, no parity), a frame is start 0, data bits 0 to 7 LSB first, stop 1: 10 bits.
- R4: With long mode and parity off, a frame is start 0, nine data bits (bits 0 to 7 from the data register, bit 8 from format bit 3), stop 1: 11 bits.
- R5: With short mode and parity on, a frame is start 0, data bits 0 to 6, a parity bit, stop 1. Format bit 2 = 0 gives even parity (the count of ones over data and parity is even); 1 gives odd.
- R6: With long mode and parity on, a frame is start 0, data bits 0 to 7, a parity bit of the type chosen as in R5, stop 1.
- R7: Each bit lasts exactly one bit_tick period, and when data is waiting the next start bit follows the stop bit with no gap.
- R8: Writing the data register clears both status flags. Holding empty sets when the data enters the shift register. Transmission done sets when a stop bit ends with no data waiting.
- R9: irq is 1 exactly when (control bit 7 and holding empty) or (control bit 6 and transmission done).
- R10: With transmit enable 0, txd stays 1 and no frame starts, even with data waiting. Clearing transmit enable during a frame lets that frame finish.
- R11: With break and transmit enable both 1, txd is held 0 for a whole number of frame lengths and takes priority over waiting data. After break is cleared, exactly one bit time of 1 is sent before the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output line, idle high |
| irq | output | 1 | Transmitter interrupt request |

## Verification
The bench decodes each of the four character formats with both parity types. A design that placed the parity bit after the data, instead of in place of the top data bit, would show up as a wrong bit and a longer frame. It measures run lengths on the line to pin down single-tick bit timing and the zero-gap back-to-back case, where an off-by-one loader adds an idle bit. It also times a break cleared in mid-character: the break must end on a frame boundary and be followed by exactly one high bit before queued data starts. Finally, it drops the transmit enable during a frame and checks that the frame still runs its full length and that the status flags never set while data is held back.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int FRAME_MAX = 11;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);
    localparam int DATA_W    = 9;

    typedef struct packed {
        logic empty_ie;
        logic done_ie;
        logic rxfull_ie;
        logic idle_ie;
        logic tx_en;
        logic rx_en;
        logic rx_wake;
        logic brk;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       bit8;
        logic       par_odd;
        logic       par_en;
        logic       long_mode;
    } fmt_t;

    typedef struct packed {
        logic par_odd;
        logic par_en;
        logic long_mode;
    } cfg_t;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_FMT  = 2'd1,
        A_DATA = 2'd2,
        A_STAT = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_DATA,
        SH_BREAK,
        SH_MARK
    } sh_state_t;

    function automatic logic [CNT_W-1:0] frame_len(cfg_t c);
        return c.long_mode ? CNT_W'(11) : CNT_W'(10);
    endfunction

    // start at bit 0, data LSB first, parity replaces the top data slot
    function automatic logic [FRAME_MAX-1:0] build_frame(logic [DATA_W-1:0] d, cfg_t c);
        logic [FRAME_MAX-1:0] v;
        logic [CNT_W-1:0]     nd;
        logic                 p;
        v  = '1;
        v[0] = 1'b0;
        nd = c.long_mode ? CNT_W'(9) : CNT_W'(8);
        if (c.par_en) nd = nd - CNT_W'(1);
        p  = c.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < nd) begin
                v[CNT_W'(i + 1)] = d[i];
                p = p ^ d[i];
            end
        end
        if (c.par_en) v[nd + CNT_W'(1)] = p;
        return v;
    endfunction

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              load,
    input  logic              went_idle,
    output logic              tx_en,
    output logic              brk,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] data9,
    output logic              pending,
    output logic              irq
);

    ctrl_t      ctrl;
    fmt_t       fmt;
    logic [7:0] dlo;
    logic       empty;
    logic       done;
    logic       wr_data;

    assign wr_data = wr_en && (addr_e'(addr) == A_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            fmt     <= '0;
            dlo     <= '0;
            pending <= 1'b0;
            empty   <= 1'b1;
            done    <= 1'b1;
        end else begin
            if (load) begin
                pending <= 1'b0;
                empty   <= 1'b1;
            end
            if (went_idle && !pending) done <= 1'b1;
            if (wr_en) begin
                case (addr_e'(addr))
                    A_CTRL: ctrl <= ctrl_t'(wdata);
                    A_FMT:  fmt  <= fmt_t'({4'b0000, wdata[3:0]});
                    A_DATA: begin
                        dlo     <= wdata;
                        pending <= 1'b1;
                        empty   <= 1'b0;
                        done    <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr_e'(addr))
            A_CTRL:  rdata = ctrl;
            A_FMT:   rdata = fmt;
            A_DATA:  rdata = dlo;
            default: rdata = {6'b000000, done, empty};
        endcase
    end

    assign tx_en = ctrl.tx_en;
    assign brk   = ctrl.brk;
    assign cfg   = '{par_odd: fmt.par_odd, par_en: fmt.par_en, long_mode: fmt.long_mode};
    assign data9 = {fmt.bit8, dlo};
    assign irq   = (ctrl.empty_ie && empty) || (ctrl.done_ie && done);

    p_write_clears_r8: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (!empty && !done));

    p_load_sets_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_data) |=> empty);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.empty_ie && !ctrl.done_ie) |-> !irq);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              brk,
    input  cfg_t              cfg,
    input  logic [DATA_W-1:0] data9,
    input  logic              pending,
    output logic              load,
    output logic              went_idle,
    output logic              txd
);

    sh_state_t            st, st_n;
    logic [FRAME_MAX-1:0] frame, frame_n;
    logic [CNT_W-1:0]     cnt, cnt_n;

    always_comb begin
        st_n      = st;
        frame_n   = frame;
        cnt_n     = cnt;
        load      = 1'b0;
        went_idle = 1'b0;
        if (tick) begin
            if (st == SH_IDLE || cnt == '0) begin
                if (st == SH_BREAK && !(tx_en && brk)) begin
                    st_n    = SH_MARK;
                    frame_n = '1;
                    cnt_n   = '0;
                end else if (tx_en && brk) begin
                    st_n    = SH_BREAK;
                    frame_n = '0;
                    cnt_n   = frame_len(cfg) - CNT_W'(1);
                end else if (tx_en && pending) begin
                    st_n    = SH_DATA;
                    frame_n = build_frame(data9, cfg);
                    cnt_n   = frame_len(cfg) - CNT_W'(1);
                    load    = 1'b1;
                end else begin
                    st_n      = SH_IDLE;
                    frame_n   = '1;
                    cnt_n     = '0;
                    went_idle = (st != SH_IDLE);
                end
            end else begin
                frame_n = {1'b1, frame[FRAME_MAX-1:1]};
                cnt_n   = cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SH_IDLE;
            frame <= '1;
            cnt   <= '0;
        end else begin
            st    <= st_n;
            frame <= frame_n;
            cnt   <= cnt_n;
        end
    end

    assign txd = frame[0];

    p_moves_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(txd));

    p_off_stays_high_r10: assert property (@(posedge clk) disable iff (rst)
        (st == SH_IDLE && !tx_en) |=> txd);

    p_break_low_r11: assert property (@(posedge clk) disable iff (rst)
        (st == SH_BREAK) |-> !txd);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       bit_tick,
    output logic       txd,
    output logic       irq
);

    logic              load;
    logic              went_idle;
    logic              tx_en;
    logic              brk;
    cfg_t              cfg;
    logic [DATA_W-1:0] data9;
    logic              pending;

    sertx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .load      (load),
        .went_idle (went_idle),
        .tx_en     (tx_en),
        .brk       (brk),
        .cfg       (cfg),
        .data9     (data9),
        .pending   (pending),
        .irq       (irq)
    );

    sertx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (bit_tick),
        .tx_en     (tx_en),
        .brk       (brk),
        .cfg       (cfg),
        .data9     (data9),
        .pending   (pending),
        .load      (load),
        .went_idle (went_idle),
        .txd       (txd)
    );

endmodule

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       irq;
    logic [2:0] tcnt = 3'd0;

    int nchk = 0;
    int nerr = 0;

    sertx_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .bit_tick(bit_tick), .txd(txd), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // one tick every 8 clocks
    always @(negedge clk) begin
        tcnt     <= tcnt + 3'd1;
        bit_tick <= (tcnt == 3'd7);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_level(input logic lvl);
        int t = 0;
        while (txd !== lvl && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic run_len(input logic lvl, output int n);
        wait_level(lvl);
        n = 0;
        while (txd === lvl && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic wait_done();
        logic [7:0] v;
        int t = 0;
        rd(2'd3, v);
        while (!v[1] && t < 5000) begin @(negedge clk); rd(2'd3, v); t++; end
        @(negedge clk);
    endtask

    // count cycles where txd is high over a window
    task automatic watch_high(input int cyc, output int highs);
        highs = 0;
        for (int i = 0; i < cyc; i++) begin
            if (txd === 1'b1) highs++;
            @(negedge clk);
        end
    endtask

    function automatic int expect_frame(input logic [8:0] d, input logic lng,
                                        input logic pen, input logic odd, output int len);
        int v = 0;
        int k = 1;
        int nd = lng ? 9 : 8;
        logic p = odd;
        if (pen) nd = nd - 1;
        for (int i = 0; i < nd; i++) begin
            if (d[i]) v = v | (1 << k);
            p = p ^ d[i];
            k++;
        end
        if (pen) begin
            if (p) v = v | (1 << k);
            k++;
        end
        v = v | (1 << k);
        len = k + 1;
        return v;
    endfunction

    task automatic grab(input int len, output int v);
        v = 0;
        wait_level(1'b0);
        repeat (4) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            if (txd === 1'b1) v = v | (1 << i);
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "txd after reset", int'(txd), 1);
        chk("R1", "irq after reset", int'(irq), 0);
        rd(2'd0, v); chk("R1", "control after reset", int'(v), 0);
        rd(2'd1, v); chk("R1", "format after reset", int'(v), 0);
        rd(2'd3, v); chk("R1", "status after reset", int'(v), 3);
        @(negedge clk);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        int h;
        wr(2'd0, 8'hA5);
        rd(2'd0, v); chk("R2", "control readback A5", int'(v), 8'hA5);
        @(negedge clk);
        watch_high(160, h);
        chk("R10", "break ignored with transmit off", h, 160);
        wr(2'd0, 8'h5A);
        rd(2'd0, v); chk("R2", "control readback 5A", int'(v), 8'h5A);
        chk("R9", "irq from done enable", int'(irq), 1);
        @(negedge clk);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_frame(input string req, input logic [7:0] f, input logic [7:0] d);
        int len, expv, actv;
        expv = expect_frame({f[3], d}, f[0], f[1], f[2], len);
        wr(2'd1, f);
        wr(2'd0, 8'h08);
        wr(2'd2, d);
        grab(len, actv);
        chk(req, $sformatf("frame fmt=%0h data=%0h", f, d), actv, expv);
        wait_done();
    endtask

    task automatic t_timing();
        int n;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h08);
        wr(2'd2, 8'h02);
        run_len(1'b0, n);
        chk("R7", "start plus one zero bit length", n, 16);
        wait_done();
        wr(2'd2, 8'hFF);
        wait_level(1'b0);
        wr(2'd2, 8'hFF);
        run_len(1'b1, n);
        chk("R7", "ones plus stop before next start", n, 72);
        run_len(1'b0, n);
        chk("R7", "second start bit length", n, 8);
        wait_done();
    endtask

    task automatic t_flags();
        logic [7:0] v;
        wr(2'd0, 8'h08);
        rd(2'd3, v); chk("R8", "status idle", int'(v), 3);
        @(negedge clk);
        wr(2'd2, 8'h55);
        rd(2'd3, v); chk("R8", "status after data write", int'(v), 0);
        chk("R9", "irq with enables off", int'(irq), 0);
        wait_level(1'b0);
        rd(2'd3, v); chk("R8", "status after load", int'(v), 1);
        @(negedge clk);
        wr(2'd0, 8'h88);
        chk("R9", "irq from empty enable", int'(irq), 1);
        wr(2'd0, 8'h48);
        chk("R9", "irq done enable before done", int'(irq), 0);
        wait_done();
        rd(2'd3, v); chk("R8", "status after frame end", int'(v), 3);
        chk("R9", "irq done enable after done", int'(irq), 1);
        @(negedge clk);
        wr(2'd0, 8'h08);
        chk("R9", "irq masked again", int'(irq), 0);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        int h, n;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        watch_high(200, h);
        chk("R10", "line high with data held", h, 200);
        rd(2'd3, v); chk("R10", "status while held", int'(v), 0);
        @(negedge clk);
        wr(2'd0, 8'h08);
        wait_level(1'b0);
        n = 1;
        wr(2'd0, 8'h00);
        while (txd === 1'b0 && n < 5000) begin n++; @(negedge clk); end
        chk("R10", "frame finishes after disable", n, 72);
        watch_high(200, h);
        chk("R10", "line idle after disabled frame", h, 200);
        rd(2'd3, v); chk("R8", "status after disabled frame", int'(v), 3);
        @(negedge clk);
    endtask

    task automatic t_break();
        int n;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h09);
        wr(2'd2, 8'h00);
        wait_level(1'b0);
        n = 0;
        while (txd === 1'b0 && n < 5000) begin
            if (n == 200) begin wr_en = 1'b1; addr = 2'd0; wdata = 8'h08; end
            else wr_en = 1'b0;
            n++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R11", "break low length in whole frames", n, 240);
        run_len(1'b1, n);
        chk("R11", "single high bit after break", n, 8);
        run_len(1'b0, n);
        chk("R11", "queued frame after break", n, 72);
        wait_done();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_frame("R3", 8'h00, 8'h5B);
        t_frame("R3", 8'h00, 8'hA4);
        t_frame("R4", 8'h09, 8'h36);
        t_frame("R4", 8'h01, 8'hC3);
        t_frame("R5", 8'h02, 8'h13);
        t_frame("R5", 8'h06, 8'h13);
        t_frame("R6", 8'h03, 8'hC4);
        t_frame("R6", 8'h07, 8'hC4);
        t_timing();
        t_flags();
        t_enable();
        t_break();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule